// File: doc/BRIEF.md
# Dual Data Pointer Unit with Word/Byte Addressing

This block keeps two independent data pointers for a small microcontroller datapath. Each pointer lives in a register one bit wider than the visible address. A per-pointer mode bit chooses word or byte addressing. In word mode the upper sixteen bits of the register form the live field, which reaches 64K words. In byte mode the lower sixteen bits form the live field, which reaches 64K bytes. Loads, readback and stepping all act on the live field only. The bit outside the live field keeps its value, and a step never carries into it.

The datapath picks a pointer with `ptr_sel`. It can load it, step it up or down, or use it for a memory access. A read access with a step is post-modify: the address is the value before the step. A write access with a step is pre-modify: the address is the stepped value. The effective address and the word/byte flag are driven combinationally for the selected pointer. Pointer updates take effect at the next clock edge.

Top module: `dptr_unit`

## Requirements
- R1: After reset both pointer registers and both mode bits are zero, so `rd_val`, `acc_addr` and `acc_word` read 0 for either pointer.
- R2: Bit i of `mode_wdata`, written when `mode_we` is high, sets the mode of pointer i: 1 selects word mode and 0 selects byte mode. `acc_word` shows the mode bit of the selected pointer.
- R3: `rd_val` shows register bits 16:1 in word mode and bits 15:0 in byte mode. A load writes only that field and leaves the other register bit unchanged.
- R4: A read access (`acc_en`=1, `acc_wr`=0) with `step_en` drives `acc_addr` with the live value before the step. The stepped value appears in `rd_val` after the clock edge.
- R5: A write access (`acc_en`=1, `acc_wr`=1) with `step_en` drives `acc_addr` with the stepped value (`step_dn`=0 adds one, 1 subtracts one). The pointer holds that value after the edge.
- R6: An increment from FFFFh wraps the live field to 0000h and leaves the bit outside the field unchanged.
- R7: A decrement from 0000h wraps the live field to FFFFh and leaves the bit outside the field unchanged.
- R8: When `ld_en` and `step_en` are both high, the load wins and the pointer takes `ld_data`.
- R9: Loads and steps change only the pointer chosen by `ptr_sel`. The other pointer keeps its value.
- R10: An access without `step_en` drives `acc_addr` with the current live value and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_wdata | input | 2 | New mode bits, one per pointer (1 = word) |
| ptr_sel | input | 1 | Selected pointer |
| ld_en | input | 1 | Load the live field of the selected pointer |
| ld_data | input | 16 | Load value |
| acc_en | input | 1 | Memory access in this cycle |
| acc_wr | input | 1 | Access direction: 1 = write, 0 = read |
| step_en | input | 1 | Step the selected pointer |
| step_dn | input | 1 | Step direction: 1 = decrement, 0 = increment |
| acc_addr | output | 16 | Effective memory address |
| acc_word | output | 1 | Access is word-wide |
| rd_val | output | 16 | Visible value of the selected pointer |

## Verification
Assertions check several properties on every cycle: the unselected pointer never moves, a load lands in the live field, read and write stepping produce the right post- and pre-modify addresses, and a step never disturbs the bit outside the live field. Some behaviour shows only when the mode is switched after an update, and only the bench's scenarios can reveal it. This covers reset values, the mapping of each mode bit to its pointer, and the reinterpretation of one register through both windows. The bench uses that view to confirm that wrap-around at FFFFh and 0000h left the hidden bit intact.

// File: rtl/dptr_unit.sv
module dptr_unit #(
  parameter int NPTR = 2,
  parameter int AW   = 16,
  localparam int SW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [NPTR-1:0] mode_wdata,
  input  logic [SW-1:0] ptr_sel,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic          step_en,
  input  logic          step_dn,
  output logic [AW-1:0] acc_addr,
  output logic          acc_word,
  output logic [AW-1:0] rd_val
);

  function automatic logic [AW-1:0] live_of(input logic [AW:0] r, input logic w);
    return w ? r[AW:1] : r[AW-1:0];
  endfunction

  function automatic logic [AW:0] put_live(input logic [AW:0] r, input logic w,
                                           input logic [AW-1:0] v);
    return w ? {v, r[0]} : {r[AW], v};
  endfunction

  logic [AW:0]     ptr_q [NPTR];
  logic [NPTR-1:0] mode_q;

  logic [AW:0]   cur;
  logic          cur_w;
  logic [AW-1:0] cur_live;
  logic [AW-1:0] step_val;

  assign cur      = ptr_q[ptr_sel];
  assign cur_w    = mode_q[ptr_sel];
  assign cur_live = live_of(cur, cur_w);
  assign step_val = step_dn ? cur_live - 1'b1 : cur_live + 1'b1;

  assign rd_val   = cur_live;
  assign acc_word = cur_w;
  assign acc_addr = (acc_en && acc_wr && step_en) ? step_val : cur_live;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPTR; i++) begin
      if (!rst_n) ptr_q[i] <= '0;
      else if (ptr_sel == SW'(i)) begin
        if (ld_en)        ptr_q[i] <= put_live(cur, cur_w, ld_data);
        else if (step_en) ptr_q[i] <= put_live(cur, cur_w, step_val);
      end
    end
  end

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_chk
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel != SW'(g)) |=> $stable(ptr_q[g]));
    end
  endgenerate

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !mode_we) |=>
      live_of(ptr_q[$past(ptr_sel)], mode_q[$past(ptr_sel)]) == $past(ld_data));

  p_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && step_en && !ld_en && !mode_we) |=>
      live_of(ptr_q[$past(ptr_sel)], mode_q[$past(ptr_sel)]) ==
      ($past(step_dn) ? $past(acc_addr) - 1'b1 : $past(acc_addr) + 1'b1));

  p_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && step_en && !ld_en && !mode_we) |=>
      live_of(ptr_q[$past(ptr_sel)], mode_q[$past(ptr_sel)]) == $past(acc_addr));

  p_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en && !mode_we) |=>
      (mode_q[$past(ptr_sel)] ? (ptr_q[$past(ptr_sel)][0] == $past(cur[0]))
                              : (ptr_q[$past(ptr_sel)][AW] == $past(cur[AW]))));

  p_nostep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !step_en && !ld_en) |=> $stable(ptr_q[$past(ptr_sel)]));

endmodule

// File: tb/sim_dptr_unit.sv
module sim_dptr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic        mode_we;
  logic [1:0]  mode_wdata;
  logic        ptr_sel;
  logic        ld_en;
  logic [15:0] ld_data;
  logic        acc_en, acc_wr, step_en, step_dn;
  logic [15:0] acc_addr, rd_val;
  logic        acc_word;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ptr_sel(ptr_sel), .ld_en(ld_en), .ld_data(ld_data), .acc_en(acc_en),
    .acc_wr(acc_wr), .step_en(step_en), .step_dn(step_dn),
    .acc_addr(acc_addr), .acc_word(acc_word), .rd_val(rd_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    mode_we = 0; ld_en = 0; acc_en = 0; acc_wr = 0; step_en = 0; step_dn = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); clear(); mode_we = 1; mode_wdata = m;
    @(negedge clk); clear();
  endtask

  task automatic load(input logic s, input logic [15:0] v);
    @(negedge clk); clear(); ptr_sel = s; ld_en = 1; ld_data = v;
    @(negedge clk); clear();
  endtask

  // one cycle of access/step; checks acc_addr before the edge
  task automatic op(input logic s, input logic a, input logic w, input logic st,
                    input logic dn, input logic [15:0] exp_addr, input string req);
    @(negedge clk); clear(); ptr_sel = s; acc_en = a; acc_wr = w; step_en = st; step_dn = dn;
    #1 chk(req, acc_addr, exp_addr);
    @(negedge clk); clear();
  endtask

  task automatic peek(input logic s, input logic [15:0] exp, input string req);
    @(negedge clk); clear(); ptr_sel = s;
    #1 chk(req, rd_val, exp);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); ptr_sel = s[0];
      #1 chk("R1 rd_val", rd_val, 0);
      chk("R1 acc_addr", acc_addr, 0);
      chk("R1 acc_word", acc_word, 0);
    end
  endtask

  task automatic t_modes();
    set_mode(2'b10);
    @(negedge clk); ptr_sel = 0; #1 chk("R2 p0 byte", acc_word, 0);
    @(negedge clk); ptr_sel = 1; #1 chk("R2 p1 word", acc_word, 1);
    set_mode(2'b01);
    @(negedge clk); ptr_sel = 0; #1 chk("R2 p0 word", acc_word, 1);
    @(negedge clk); ptr_sel = 1; #1 chk("R2 p1 byte", acc_word, 0);
  endtask

  task automatic t_fields();
    set_mode(2'b00);
    load(0, 16'hABCD);
    peek(0, 16'hABCD, "R3 byte load");
    set_mode(2'b01);
    peek(0, 16'h55E6, "R3 word view");
    load(0, 16'hFFFF);
    peek(0, 16'hFFFF, "R3 word load");
    set_mode(2'b00);
    peek(0, 16'hFFFF, "R3 bit0 kept by word load");
  endtask

  task automatic t_inc_wrap();
    op(0, 0, 0, 1, 0, 16'hFFFF, "R6 addr no access");
    peek(0, 16'h0000, "R6 wrap to 0");
    set_mode(2'b01);
    peek(0, 16'h8000, "R6 bit16 unchanged");
  endtask

  task automatic t_dec_wrap();
    set_mode(2'b00);
    load(1, 16'h0001);
    set_mode(2'b10);
    peek(1, 16'h0000, "R7 word view");
    op(1, 0, 0, 1, 1, 16'h0000, "R7 addr no access");
    peek(1, 16'hFFFF, "R7 wrap to FFFF");
    set_mode(2'b00);
    peek(1, 16'hFFFF, "R7 bit0 unchanged");
  endtask

  task automatic t_read_post();
    set_mode(2'b00);
    load(0, 16'h1000);
    op(0, 1, 0, 1, 0, 16'h1000, "R4 post-inc addr");
    peek(0, 16'h1001, "R4 post-inc value");
    op(0, 1, 0, 1, 1, 16'h1001, "R4 post-dec addr");
    peek(0, 16'h1000, "R4 post-dec value");
  endtask

  task automatic t_write_pre();
    op(0, 1, 1, 1, 0, 16'h1001, "R5 pre-inc addr");
    peek(0, 16'h1001, "R5 pre-inc value");
    op(0, 1, 1, 1, 1, 16'h1000, "R5 pre-dec addr");
    peek(0, 16'h1000, "R5 pre-dec value");
    set_mode(2'b10);
    load(1, 16'h00FF);
    @(negedge clk); ptr_sel = 1; acc_en = 1; acc_wr = 1; step_en = 1; step_dn = 0;
    #1 chk("R5 word pre-inc addr", acc_addr, 16'h0100);
    chk("R5 word flag", acc_word, 1);
    @(negedge clk); clear();
    peek(1, 16'h0100, "R5 word pre-inc value");
  endtask

  task automatic t_nostep();
    op(1, 1, 0, 0, 0, 16'h0100, "R10 read addr");
    op(1, 1, 1, 0, 0, 16'h0100, "R10 write addr");
    peek(1, 16'h0100, "R10 unchanged");
  endtask

  task automatic t_load_wins();
    @(negedge clk); clear(); ptr_sel = 1; ld_en = 1; ld_data = 16'h4321; step_en = 1;
    @(negedge clk); clear();
    peek(1, 16'h4321, "R8 load over inc");
    @(negedge clk); ptr_sel = 1; ld_en = 1; ld_data = 16'h0000; step_en = 1; step_dn = 1;
    @(negedge clk); clear();
    peek(1, 16'h0000, "R8 load over dec");
  endtask

  task automatic t_indep();
    set_mode(2'b00);
    load(0, 16'h2222);
    load(1, 16'h3333);
    op(0, 0, 0, 1, 0, 16'h2222, "R9 step p0");
    op(0, 1, 1, 1, 0, 16'h2224, "R9 step p0 again");
    peek(1, 16'h3333, "R9 p1 untouched");
    load(1, 16'h7777);
    peek(0, 16'h2224, "R9 p0 untouched");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear(); mode_wdata = 0; ptr_sel = 0; ld_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_modes();
    t_fields();
    t_inc_wrap();
    t_dec_wrap();
    t_read_post();
    t_write_pre();
    t_nostep();
    t_load_wins();
    t_indep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule